// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI bus master that software drives through a small 32-bit register port. Software queues words of a build-time width into a transmit FIFO. The block shifts each word out on the serial clock and data-out lines, and it captures the serial data-in line into a receive FIFO. The clock polarity, the clock phase, the bit order and an internal loopback are chosen per transfer through the control register.

A hold bit in the control register lets software fill the transmit queue before any shifting begins. When software clears the bit, the queued words go out back to back. The slave-select outputs come straight from a register that software writes. In manual mode they always follow that register. Otherwise they follow it only while a word is on the wire and sit at all ones when idle.

The serial clock divider, the word width, the FIFO depth and the number of select lines are build-time parameters. The block has no slave mode, so the fault flag in the status register always reads zero.

Top module: `spim_top`

## Requirements
- R1: After reset, control reads 0, status reads 0x05, slave-select reads all ones, every select output is high, the serial clock is low, and receive data and unmapped addresses read 0. The register offsets are control 0x60, status 0x64, transmit data 0x68, receive data 0x6C and slave select 0x70.
- R2: The control bits are loopback bit 0, enable bit 1, master bit 2, polarity bit 3, phase bit 4, transmit flush bit 5, receive flush bit 6, manual select bit 7, hold bit 8 and LSB-first bit 9. Every bit except 5 and 6 reads back as written. Bits 5 and 6 always read as 0.
- R3: A word is shifted only while enable and master are both 1 and hold is 0. While that is not true, queued words stay in the transmit FIFO and the serial clock does not move. Once shifting is allowed, the queued words go out back to back. Each word takes 2·W·DIV+1 clocks, and the first word is loaded one clock after the control write.
- R4: The serial clock rests at the polarity bit. With phase 0, data is sampled on the leading edge. With phase 1, data is sampled on the trailing edge. Each word gives exactly W sampling edges.
- R5: With LSB-first at 0, bit W-1 is sent first. With LSB-first at 1, bit 0 is sent first. The receive word is assembled in the same order.
- R6: With loopback at 1, the receive path takes the block's own data-out line. With loopback at 0, it takes the external data-in pin.
- R7: Each transmitted word pushes one received word. A read at the receive data offset returns the oldest word zero-extended and pops it, so words come back in order.
- R8: A write to a full transmit FIFO (depth 16 by default) is dropped. Status bit 3 flags a full transmit FIFO and status bit 1 flags a full receive FIFO.
- R9: A read of an empty receive FIFO returns 0 and leaves the FIFO state unchanged.
- R10: Status bit 2 (transmit empty) becomes 1 only after the last word's final edge, not when the FIFO drains. Status bit 0 is receive empty.
- R11: Writing a control word with bit 5 or bit 6 set empties the transmit or receive FIFO in that same write.
- R12: With manual select at 1, the select outputs equal the slave-select register. With manual select at 0, they equal the register while a word is shifting and are all ones otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Write strobe, one clock per write |
| busWrData | input | 32 | Write data |
| busRd | input | 1 | Read strobe; pops the receive FIFO at the receive data offset |
| busRdData | output | 32 | Read data, combinational from busAddr |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiSsN | output | NUM_SS | Slave-select lines, active low |

## Verification
A register write takes effect at the clock edge that samples it. With the defaults, a transfer released at edge C loads at C+1 and finishes its k-th word at edge C+33·k. The receive word and the transmit-empty flag appear right after that edge. The bench drives and samples on the falling clock edge, and it checks transmit empty at both C+98 and C+99 for a three-word burst to pin that boundary. Reads are combinational, so a read's data is taken within the same cycle, before the edge that pops the word.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_SSEL = 8'h70;

  localparam int B_LOOP  = 0;
  localparam int B_EN    = 1;
  localparam int B_MSTR  = 2;
  localparam int B_CPOL  = 3;
  localparam int B_CPHA  = 4;
  localparam int B_TXCLR = 5;
  localparam int B_RXCLR = 6;
  localparam int B_MANSS = 7;
  localparam int B_HOLD  = 8;
  localparam int B_LSB   = 9;

  typedef struct packed {
    logic loop;
    logic en;
    logic mstr;
    logic cpol;
    logic cpha;
    logic manSs;
    logic hold;
    logic lsb;
  } cfg_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic busy;
    logic load;
    logic sample;
    logic shift;
    logic done;
  } strobe_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_MAX);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk)
    if (doPush) mem[wrPtr] <= din;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_MAX) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_MAX) ? '0 : rdPtr + AW'(1);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R8: a push into a full queue leaves it full and the write pointer still
  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clr) |=> (full && $stable(wrPtr)));

  // R9: a pop from an empty queue changes nothing
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push && !clr) |=> (empty && $stable(rdPtr)));
endmodule

// File: rtl/spim_seq.sv
module spim_seq
  import spim_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  logic    txAvail,
  output strobe_t strb,
  output logic    sclk
);
  localparam int NEDGE = 2 * WORD_W;
  localparam int EW    = $clog2(NEDGE);
  localparam int DW    = $clog2(CLK_DIV) + 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(NEDGE - 1);
  localparam logic [DW-1:0] DIV_MAX   = DW'(CLK_DIV - 1);

  logic          busy, startOk, tick, lead, unusedCfg;
  logic [DW-1:0] divCnt;
  logic [EW-1:0] edgeIdx;

  assign startOk   = cfg.en && cfg.mstr && !cfg.hold && txAvail;
  assign tick      = busy && (divCnt == DIV_MAX);
  assign lead      = !edgeIdx[0];
  assign unusedCfg = cfg.loop ^ cfg.lsb ^ cfg.manSs;

  always_comb begin
    strb.busy   = busy;
    strb.load   = !busy && startOk;
    strb.sample = tick && (lead ^ cfg.cpha);
    strb.shift  = tick && !(lead ^ cfg.cpha) && (edgeIdx != '0);
    strb.done   = tick && (edgeIdx == LAST_EDGE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divCnt  <= '0;
      edgeIdx <= '0;
      sclk    <= 1'b0;
    end else if (!busy) begin
      sclk    <= cfg.cpol;
      divCnt  <= '0;
      edgeIdx <= '0;
      if (startOk) busy <= 1'b1;
    end else if (tick) begin
      divCnt  <= '0;
      sclk    <= !sclk;
      edgeIdx <= edgeIdx + EW'(1);
      if (edgeIdx == LAST_EDGE) busy <= 1'b0;
    end else begin
      divCnt <= divCnt + DW'(1);
    end
  end

  // R3: with hold set, an idle engine stays idle
  a_r3_hold_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfg.hold) |=> !busy);

  // R4: an even number of edges per word returns the clock to its rest level
  a_r4_sclk_rest: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (sclk == cfg.cpol));
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_SS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWrData,
  input  logic              busRd,
  output logic [31:0]       busRdData,
  input  strobe_t           strb,
  output cfg_t              cfg,
  output logic              txAvail,
  input  logic              miso,
  output logic              mosi,
  output logic [NUM_SS-1:0] ssN
);
  logic selCtrl, selStat, selTx, selRx, selSs;
  logic txClr, rxClr, txPush, rxPop, misoEff, unusedWr;
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic [WORD_W-1:0] txHead, rxHead, txSh, rxSh, rxNext;
  logic [NUM_SS-1:0] ssReg;
  logic [31:0]       ctrlRd;

  assign selCtrl  = (busAddr == OFS_CTRL);
  assign selStat  = (busAddr == OFS_STAT);
  assign selTx    = (busAddr == OFS_TXD);
  assign selRx    = (busAddr == OFS_RXD);
  assign selSs    = (busAddr == OFS_SSEL);
  assign txClr    = busWr && selCtrl && busWrData[B_TXCLR];
  assign rxClr    = busWr && selCtrl && busWrData[B_RXCLR];
  assign txPush   = busWr && selTx;
  assign rxPop    = busRd && selRx;
  assign unusedWr = ^busWrData;
  assign txAvail  = !txEmpty;

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .clr(txClr), .push(txPush),
    .din(busWrData[WORD_W-1:0]), .pop(strb.load),
    .dout(txHead), .empty(txEmpty), .full(txFull));

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .clr(rxClr), .push(strb.done),
    .din(rxNext), .pop(rxPop),
    .dout(rxHead), .empty(rxEmpty), .full(rxFull));

  assign mosi    = cfg.lsb ? txSh[0] : txSh[WORD_W-1];
  assign misoEff = cfg.loop ? mosi : miso;
  assign ssN     = (cfg.manSs || strb.busy) ? ssReg : '1;

  always_comb begin
    rxNext = rxSh;
    if (strb.sample)
      rxNext = cfg.lsb ? {misoEff, rxSh[WORD_W-1:1]} : {rxSh[WORD_W-2:0], misoEff};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg   <= '0;
      ssReg <= '1;
      txSh  <= '0;
      rxSh  <= '0;
    end else begin
      if (busWr && selCtrl)
        cfg <= '{loop: busWrData[B_LOOP], en: busWrData[B_EN], mstr: busWrData[B_MSTR],
                 cpol: busWrData[B_CPOL], cpha: busWrData[B_CPHA], manSs: busWrData[B_MANSS],
                 hold: busWrData[B_HOLD], lsb: busWrData[B_LSB]};
      if (busWr && selSs) ssReg <= busWrData[NUM_SS-1:0];
      if (strb.load)       txSh <= txHead;
      else if (strb.shift) txSh <= cfg.lsb ? (txSh >> 1) : (txSh << 1);
      rxSh <= rxNext;
    end
  end

  always_comb begin
    ctrlRd          = '0;
    ctrlRd[B_LOOP]  = cfg.loop;
    ctrlRd[B_EN]    = cfg.en;
    ctrlRd[B_MSTR]  = cfg.mstr;
    ctrlRd[B_CPOL]  = cfg.cpol;
    ctrlRd[B_CPHA]  = cfg.cpha;
    ctrlRd[B_MANSS] = cfg.manSs;
    ctrlRd[B_HOLD]  = cfg.hold;
    ctrlRd[B_LSB]   = cfg.lsb;
    busRdData = '0;
    if (selCtrl)      busRdData = ctrlRd;
    else if (selStat) busRdData = 32'({txFull, txEmpty && !strb.busy, rxFull, rxEmpty});
    else if (selRx)   busRdData = rxEmpty ? '0 : 32'(rxHead);
    else if (selSs)   busRdData = 32'(ssReg);
  end

  // R11: a flush write leaves the transmit queue empty on the next cycle
  a_r11_tx_flush: assert property (@(posedge clk) disable iff (!rstN)
    txClr |=> txEmpty);

  // R7: a finished word lands in a receive queue that had room
  a_r7_rx_push: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && !rxFull && !rxClr) |=> !rxEmpty);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int CLK_DIV    = 2,
  parameter int NUM_SS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWrData,
  input  logic              busRd,
  output logic [31:0]       busRdData,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_SS-1:0] spiSsN
);
  cfg_t    cfg;
  strobe_t strb;
  logic    txAvail;

  spim_seq #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_seq (
    .clk(clk), .rstN(rstN), .cfg(cfg), .txAvail(txAvail),
    .strb(strb), .sclk(spiSclk));

  spim_dp #(.WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH), .NUM_SS(NUM_SS)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRd(busRd), .busRdData(busRdData),
    .strb(strb), .cfg(cfg), .txAvail(txAvail),
    .miso(spiMiso), .mosi(spiMosi), .ssN(spiSsN));
endmodule

// File: tb/sim_spim_top.sv
module sim_spim_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int DEPTH      = 16;
  localparam int WORD_CYC   = 2 * W * 2 + 1;

  localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                         A_RXD = 8'h6C, A_SSEL = 8'h70;
  localparam logic [31:0] C_LOOP = 32'h001, C_EN = 32'h002, C_MSTR = 32'h004,
                          C_CPOL = 32'h008, C_CPHA = 32'h010, C_TXCLR = 32'h020,
                          C_RXCLR = 32'h040, C_MAN = 32'h080, C_HOLD = 32'h100,
                          C_LSB = 32'h200;

  // {cpol, cpha, lsb, externalLoop, word}
  localparam logic [11:0] VEC [6] = '{12'h0A5, 12'h43C, 12'h896, 12'hE1E, 12'h3C1, 12'hD7E};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        spiSclk, spiMosi, spiMiso;
  logic [3:0]  spiSsN;
  logic        extLoop = 1'b0;
  logic        monCpol = 1'b0, monCpha = 1'b0;
  logic [31:0] cap = '0;
  int          capBits = 0;
  int          nChk = 0, nErr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign spiMiso = extLoop ? spiMosi : 1'b0;

  spim_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRd(busRd), .busRdData(busRdData),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiSsN(spiSsN));

  // slave-side monitor: shifts in data-out on the mode's sampling edge
  always @(spiSclk)
    if (!spiSsN[0] && (spiSclk == (monCpol ^ !monCpha))) begin
      cap = {cap[30:0], spiMosi};
      capBits++;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // both tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] x);
    for (int k = 0; k < 8; k++) rev8[k] = x[7-k];
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++; nChk++;
    $display("FAIL R3 watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    logic [31:0] d, ctl;
    logic [11:0] v;
    int capStart;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h05);
    rd(A_SSEL, d); chk("R1 ssel", d, 32'hF);
    chk("R1 ssN", 32'(spiSsN), 32'hF);
    chk("R1 sclk", 32'(spiSclk), 32'h0);
    rd(A_RXD, d);  chk("R1 rxd", d, 32'h0);
    rd(8'h00, d);  chk("R1 unmapped", d, 32'h0);

    // R2 readback
    wr(A_CTRL, 32'h3FF); rd(A_CTRL, d); chk("R2 ctrl all", d, 32'h39F);
    wr(A_CTRL, C_LOOP);  rd(A_CTRL, d); chk("R2 loop bit", d, C_LOOP);
    wr(A_CTRL, 32'h0);

    // vector table: R4 R5 R6 R7 R10 over modes
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      monCpol = v[11]; monCpha = v[10]; extLoop = v[8];
      ctl = C_EN | C_MSTR | C_MAN | (v[11] ? C_CPOL : 0) | (v[10] ? C_CPHA : 0)
            | (v[9] ? C_LSB : 0) | (v[8] ? 0 : C_LOOP);
      wr(A_CTRL, ctl | C_HOLD);
      wr(A_TXD, 32'(v[7:0]));
      wr(A_SSEL, 32'hE);
      capStart = capBits;
      wr(A_CTRL, ctl);
      repeat (WORD_CYC) @(posedge clk);
      @(negedge clk);
      chk("R4 edge count", 32'(capBits - capStart), 32'd8);
      chk("R4 sclk rest", 32'(spiSclk), 32'(v[11]));
      chk("R5 bit order", 32'(cap[7:0]), 32'(v[9] ? rev8(v[7:0]) : v[7:0]));
      rd(A_STAT, d); chk("R10 status after word", d, 32'h04);
      rd(A_RXD, d);  chk("R6 R7 rx word", d, 32'(v[7:0]));
      wr(A_SSEL, 32'hF);
    end
    extLoop = 1'b0; monCpol = 1'b0; monCpha = 1'b0;

    // R3 hold and back-to-back, R10 boundary
    ctl = C_EN | C_MSTR | C_MAN | C_LOOP;
    wr(A_CTRL, ctl | C_HOLD);
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R3 sclk held", 32'(spiSclk), 32'h0);
    rd(A_STAT, d); chk("R3 held status", d, 32'h01);
    wr(A_CTRL, ctl);
    repeat (3 * WORD_CYC - 1) @(posedge clk);
    @(negedge clk);
    rd(A_STAT, d); chk("R10 before last edge", d, 32'h00);
    rd(A_STAT, d); chk("R10 after last edge", d, 32'h04);
    rd(A_RXD, d);  chk("R7 order 1", d, 32'h11);
    rd(A_RXD, d);  chk("R7 order 2", d, 32'h22);
    rd(A_RXD, d);  chk("R7 order 3", d, 32'h33);

    // R8 full drop, R9 empty read
    wr(A_CTRL, ctl | C_HOLD);
    for (int i = 0; i <= DEPTH; i++) wr(A_TXD, 32'((i * 9 + 3) & 8'hFF));
    rd(A_STAT, d); chk("R8 tx full", d, 32'h09);
    wr(A_CTRL, ctl);
    repeat (DEPTH * WORD_CYC + 4) @(posedge clk);
    @(negedge clk);
    rd(A_STAT, d); chk("R8 rx full", d, 32'h06);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, d); chk("R8 kept word", d, 32'((i * 9 + 3) & 8'hFF));
    end
    rd(A_RXD, d);  chk("R8 R9 dropped word absent", d, 32'h0);
    rd(A_STAT, d); chk("R9 status unchanged", d, 32'h05);
    rd(A_RXD, d);  chk("R9 empty read", d, 32'h0);

    // R11 flush pulses
    wr(A_CTRL, ctl | C_HOLD);
    wr(A_TXD, 32'h44); wr(A_TXD, 32'h55);
    rd(A_STAT, d); chk("R11 tx queued", d, 32'h01);
    wr(A_CTRL, ctl | C_HOLD | C_TXCLR);
    rd(A_STAT, d); chk("R11 tx flushed", d, 32'h05);
    rd(A_CTRL, d); chk("R11 R2 flush bit reads 0", d, ctl | C_HOLD);
    wr(A_TXD, 32'h66); wr(A_TXD, 32'h77);
    wr(A_CTRL, ctl);
    repeat (2 * WORD_CYC + 4) @(posedge clk);
    @(negedge clk);
    rd(A_STAT, d); chk("R11 rx filled", d, 32'h04);
    wr(A_CTRL, ctl | C_RXCLR);
    rd(A_STAT, d); chk("R11 rx flushed", d, 32'h05);
    rd(A_RXD, d);  chk("R11 rx read after flush", d, 32'h0);

    // R12 select modes, R3 enable gate
    wr(A_CTRL, C_MAN);
    wr(A_SSEL, 32'h5);
    chk("R12 manual follows", 32'(spiSsN), 32'h5);
    wr(A_CTRL, C_MSTR | C_LOOP);
    wr(A_SSEL, 32'h6);
    chk("R12 auto idle", 32'(spiSsN), 32'hF);
    wr(A_TXD, 32'h5A);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(A_STAT, d); chk("R3 enable gate", d, 32'h01);
    wr(A_CTRL, C_EN | C_MSTR | C_LOOP);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R12 auto busy", 32'(spiSsN), 32'h6);
    repeat (25) @(posedge clk);
    @(negedge clk);
    chk("R12 auto after", 32'(spiSsN), 32'hF);
    rd(A_RXD, d); chk("R3 R7 gated word sent", d, 32'h5A);

    finishRun();
  end
endmodule